// File: doc/BRIEF.md
# Memory-Scanning Word CRC Engine

This block walks a region of on-chip non-volatile memory and reduces it to a 32-bit check value. It reads the region as 256-bit memory words, issued as sequential bursts, and folds each 32-bit lane of every word into a running CRC. The CRC uses generator 0x04C11DB7 and shifts most-significant bit first, with no bit reflection. The state starts from zero, and after every 32-bit lane a fixed constant 0x55555555 is XORed into it. Because of this, an image that stores its own CRC as its last word always checks to 0x55555555.

Software picks the region in one of two ways. In address mode it gives an inclusive pair of byte addresses. In sector mode it gives a first sector index and a sector count. It also selects a burst length, clears the result and starts the scan. The engine then drives a request/valid read port, holds busy while it works, pulses done at the end, and keeps the result until the next clear.

Top module: `flash_crc_scan`

## Requirements
- R1: Each 32-bit lane `w` updates the state as `s = step32(s ^ w) ^ 32'h55555555`. `step32` applies 32 left shifts and XORs in 0x04C11DB7 whenever the bit shifted out is 1. An all-zero lane folded into a zero state gives 0x55555555.
- R2: After reset, `result` is 0 and `busy` and `done` are low. `cmd_clear` while idle sets `result` to 0 on the next cycle. `cmd_clear` while busy is ignored.
- R3: In a memory word, byte offset b (0..31) sits at `mem_rdata[8b+7:8b]`. Lane k is bits `32k+31:32k`, so the lowest byte address of a lane is in its bits 7:0. Lanes are folded in ascending address order, one lane per clock.
- R4: Memory words are read as bursts. `mem_addr` is a 256-bit-word index, and the first burst starts at the first word of the region. Each burst has length min(selected burst, words remaining). One beat is accepted per `mem_rvalid && mem_rready`.
- R5: `burst_code` 0, 1, 2 and 3 select 4, 16, 64 and 256 words. Reset selects code 1. A `burst_wr` replaces the stored code completely, so any code can follow any other.
- R6: In address mode (`cfg_sector_mode`=0), the lanes from `cfg_start_addr[ADDR_W-1:2]` through `cfg_end_addr[ADDR_W-1:2]` inclusive are folded. Bits 1:0 of both addresses have no effect. Lanes of the first and last memory words that lie outside that range are skipped.
- R7: In sector mode, the region is `cfg_sector_num` whole sectors of 2^SECT_LOG2 bytes, starting at byte `cfg_sector * 2^SECT_LOG2`.
- R8: `done` is high for exactly one cycle, the first cycle in which `busy` is low after a scan. `result` stays unchanged while idle until a clear.
- R9: `cmd_start` while busy is ignored.
- R10: A start with no clear before it continues from the current `result`.
- R11: When the last lane of a region holds the CRC of the lanes before it (computed from a zero state), the scan returns 0x55555555.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_clear | input | 1 | Zero the result (idle only) |
| cmd_start | input | 1 | Begin a scan (idle only) |
| cfg_sector_mode | input | 1 | 1 = sector region, 0 = address region |
| burst_wr | input | 1 | Load `burst_code` |
| burst_code | input | 2 | Burst length code |
| cfg_start_addr | input | ADDR_W | First byte address (address mode) |
| cfg_end_addr | input | ADDR_W | Last byte address, inclusive (address mode) |
| cfg_sector | input | ADDR_W-SECT_LOG2 | First sector index |
| cfg_sector_num | input | ADDR_W-SECT_LOG2+1 | Sector count, at least 1 |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| result | output | 32 | CRC value |
| mem_req | output | 1 | Burst request strobe |
| mem_addr | output | ADDR_W-5 | Burst start, memory-word index |
| mem_len | output | 9 | Burst length in memory words |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rready | output | 1 | Engine can take a beat |
| mem_rdata | input | 256 | Read beat data |

## Verification
The bench builds the engine with ADDR_W=13 and SECT_LOG2=8, which gives an 8 KiB memory of 256 words in 32 sectors of 256 bytes. With that size the bench can scan the whole memory once per burst code, so even the 256-word burst appears as a single request. Every start/end lane pair inside one memory word is swept, along with several sector windows. The low address bits, CRC self-check images and known-answer lanes are all reachable in a few thousand cycles.

// File: rtl/crc_scan_pkg.sv
// Shared constants, types and helpers for the memory-scanning CRC engine.
// Assumes the memory word is 256 bits and the CRC lane is 32 bits.
package crc_scan_pkg;
    localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;
    localparam logic [31:0] CRC_XOROUT = 32'h55555555;
    localparam int MEM_W      = 256;
    localparam int LANE_W     = 32;
    localparam int LANES      = MEM_W / LANE_W;
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int WORD_LOG2  = $clog2(MEM_W / 8);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_BEATS = 2'd2
    } seq_state_t;

    // Burst code to memory-word count: 4 << (2*code).
    function automatic logic [8:0] burst_words(input logic [1:0] code);
        return 9'd4 << {code, 1'b0};
    endfunction
endpackage

// File: rtl/crc_lane_fold.sv
// Combinational fold of one 32-bit lane into the CRC state.
// Assumes MSB-first processing, no reflection, fixed XOR after each lane.
module crc_lane_fold
    import crc_scan_pkg::*;
(
    input  logic [31:0] state_i,
    input  logic [31:0] data_i,
    output logic [31:0] next_o
);
    logic [31:0] s;

    // Purpose: XOR the lane, run 32 polynomial steps, apply the constant.
    always_comb begin
        s = state_i ^ data_i;
        for (int i = 0; i < LANE_W; i++) begin
            s = s[31] ? ((s << 1) ^ CRC_POLY) : (s << 1);
        end
        next_o = s ^ CRC_XOROUT;
    end
endmodule

// File: rtl/crc_region_map.sv
// Turns the region configuration into a first memory word, a word count
// and an inclusive lane-address window.
// Assumes start <= end in address mode and a nonzero sector count that
// stays inside the memory in sector mode.
module crc_region_map #(
    parameter int ADDR_W    = 20,
    parameter int SECT_LOG2 = 17
) (
    input  logic                          sector_mode_i,
    input  logic [ADDR_W-1:0]             start_addr_i,
    input  logic [ADDR_W-1:0]             end_addr_i,
    input  logic [ADDR_W-SECT_LOG2-1:0]   sect_first_i,
    input  logic [ADDR_W-SECT_LOG2:0]     sect_num_i,
    output logic [ADDR_W-6:0]             first_word_o,
    output logic [ADDR_W-5:0]             n_words_o,
    output logic [ADDR_W-3:0]             lo_lane_o,
    output logic [ADDR_W-3:0]             hi_lane_o
);
    localparam int WA_W    = ADDR_W - 5;
    localparam int LA_W    = ADDR_W - 2;
    localparam int SHIFT_W = SECT_LOG2 - 5;

    logic unused_low_bits;
    assign unused_low_bits = ^{start_addr_i[1:0], end_addr_i[1:0]};

    // Purpose: choose the region window from the selected mode.
    always_comb begin
        if (sector_mode_i) begin
            first_word_o = WA_W'(sect_first_i) << SHIFT_W;
            n_words_o    = (WA_W + 1)'(sect_num_i) << SHIFT_W;
            lo_lane_o    = {first_word_o, 3'b000};
            hi_lane_o    = LA_W'({n_words_o, 3'b000}) + lo_lane_o - LA_W'(1);
        end else begin
            first_word_o = start_addr_i[ADDR_W-1:5];
            n_words_o    = {1'b0, end_addr_i[ADDR_W-1:5]}
                         - {1'b0, start_addr_i[ADDR_W-1:5]} + (WA_W + 1)'(1);
            lo_lane_o    = start_addr_i[ADDR_W-1:2];
            hi_lane_o    = end_addr_i[ADDR_W-1:2];
        end
    end
endmodule

// File: rtl/crc_scan_seq.sv
// Burst and lane sequencer: issues bursts, accepts one beat at a time,
// and presents its eight lanes over eight cycles with a fold enable.
// Assumes the memory returns exactly mem_len beats per request in order.
module crc_scan_seq
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-6:0] first_word_i,
    input  logic [ADDR_W-5:0] n_words_i,
    input  logic [ADDR_W-3:0] lo_lane_i,
    input  logic [ADDR_W-3:0] hi_lane_i,
    input  logic [8:0]        bwords_i,
    input  logic              mem_rvalid_i,
    input  logic [MEM_W-1:0]  mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_req_o,
    output logic [ADDR_W-6:0] mem_addr_o,
    output logic [8:0]        mem_len_o,
    output logic              mem_rready_o,
    output logic              lane_fire_o,
    output logic [31:0]       lane_data_o
);
    localparam int WA_W = ADDR_W - 5;
    localparam int LA_W = ADDR_W - 2;
    localparam int WL_W = (WA_W + 1 > 9) ? WA_W + 1 : 9;

    seq_state_t            state_q;
    logic                  lane_run_q, done_q;
    logic [LANE_IDX_W-1:0] lane_idx_q;
    logic [8:0]            beats_left_q, bwords_q, blen;
    logic [WL_W-1:0]       words_left_q;
    logic [WA_W-1:0]       next_word_q;
    logic [LA_W-1:0]       cur_q, lo_q, hi_q;
    logic [MEM_W-1:0]      buf_q;
    logic                  beat_take;

    // Purpose: the burst length is the selected size capped by what remains.
    assign blen = (words_left_q < WL_W'(bwords_q)) ? words_left_q[8:0] : bwords_q;

    assign busy_o       = (state_q != SEQ_IDLE);
    assign done_o       = done_q;
    assign mem_req_o    = (state_q == SEQ_ISSUE);
    assign mem_addr_o   = next_word_q;
    assign mem_len_o    = blen;
    assign mem_rready_o = (state_q == SEQ_BEATS) && !lane_run_q && (beats_left_q != 9'd0);
    assign beat_take    = mem_rready_o && mem_rvalid_i;
    assign lane_fire_o  = lane_run_q && (cur_q >= lo_q) && (cur_q <= hi_q);
    assign lane_data_o  = buf_q[int'(lane_idx_q) * LANE_W +: LANE_W];

    // Purpose: the scan state machine, beat buffer and lane stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            lane_run_q   <= 1'b0;
            lane_idx_q   <= '0;
            beats_left_q <= '0;
            words_left_q <= '0;
            next_word_q  <= '0;
            cur_q        <= '0;
            lo_q         <= '0;
            hi_q         <= '0;
            bwords_q     <= 9'd16;
            buf_q        <= '0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        next_word_q  <= first_word_i;
                        words_left_q <= WL_W'(n_words_i);
                        cur_q        <= {first_word_i, 3'b000};
                        lo_q         <= lo_lane_i;
                        hi_q         <= hi_lane_i;
                        bwords_q     <= bwords_i;
                        state_q      <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: begin
                    beats_left_q <= blen;
                    next_word_q  <= next_word_q + WA_W'(blen);
                    words_left_q <= words_left_q - WL_W'(blen);
                    state_q      <= SEQ_BEATS;
                end
                SEQ_BEATS: begin
                    if (beat_take) begin
                        buf_q        <= mem_rdata_i;
                        lane_run_q   <= 1'b1;
                        lane_idx_q   <= '0;
                        beats_left_q <= beats_left_q - 9'd1;
                    end
                    if (lane_run_q) begin
                        lane_idx_q <= lane_idx_q + 1'b1;
                        cur_q      <= cur_q + 1'b1;
                        if (lane_idx_q == LANE_IDX_W'(LANES - 1)) begin
                            lane_run_q <= 1'b0;
                            if (beats_left_q == 9'd0) begin
                                if (words_left_q == '0) begin
                                    state_q <= SEQ_IDLE;
                                    done_q  <= 1'b1;
                                end else begin
                                    state_q <= SEQ_ISSUE;
                                end
                            end
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/flash_crc_scan.sv
// Top of the memory-scanning CRC engine: holds the burst selection and
// the CRC result, and wires the region map, sequencer and lane fold.
// Assumes one-cycle command pulses and a memory that honours mem_rready.
module flash_crc_scan
    import crc_scan_pkg::*;
#(
    parameter int ADDR_W    = 20,
    parameter int SECT_LOG2 = 17
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_clear,
    input  logic                        cmd_start,
    input  logic                        cfg_sector_mode,
    input  logic                        burst_wr,
    input  logic [1:0]                  burst_code,
    input  logic [ADDR_W-1:0]           cfg_start_addr,
    input  logic [ADDR_W-1:0]           cfg_end_addr,
    input  logic [ADDR_W-SECT_LOG2-1:0] cfg_sector,
    input  logic [ADDR_W-SECT_LOG2:0]   cfg_sector_num,
    output logic                        busy,
    output logic                        done,
    output logic [31:0]                 result,
    output logic                        mem_req,
    output logic [ADDR_W-6:0]           mem_addr,
    output logic [8:0]                  mem_len,
    input  logic                        mem_rvalid,
    output logic                        mem_rready,
    input  logic [MEM_W-1:0]            mem_rdata
);
    logic [1:0]        burst_code_q;
    logic [31:0]       crc_q, crc_next, lane_data;
    logic              lane_fire;
    logic [ADDR_W-6:0] first_word;
    logic [ADDR_W-5:0] n_words;
    logic [ADDR_W-3:0] lo_lane, hi_lane;

    // Purpose: stored burst code, fully replaced on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)        burst_code_q <= 2'd1;
        else if (burst_wr) burst_code_q <= burst_code;
    end

    crc_region_map #(.ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) u_map (
        .sector_mode_i (cfg_sector_mode),
        .start_addr_i  (cfg_start_addr),
        .end_addr_i    (cfg_end_addr),
        .sect_first_i  (cfg_sector),
        .sect_num_i    (cfg_sector_num),
        .first_word_o  (first_word),
        .n_words_o     (n_words),
        .lo_lane_o     (lo_lane),
        .hi_lane_o     (hi_lane)
    );

    crc_scan_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (cmd_start),
        .first_word_i (first_word),
        .n_words_i    (n_words),
        .lo_lane_i    (lo_lane),
        .hi_lane_i    (hi_lane),
        .bwords_i     (burst_words(burst_code_q)),
        .mem_rvalid_i (mem_rvalid),
        .mem_rdata_i  (mem_rdata),
        .busy_o       (busy),
        .done_o       (done),
        .mem_req_o    (mem_req),
        .mem_addr_o   (mem_addr),
        .mem_len_o    (mem_len),
        .mem_rready_o (mem_rready),
        .lane_fire_o  (lane_fire),
        .lane_data_o  (lane_data)
    );

    crc_lane_fold u_fold (
        .state_i (crc_q),
        .data_i  (lane_data),
        .next_o  (crc_next)
    );

    // Purpose: CRC result register, zeroed by an idle clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                  crc_q <= '0;
        else if (cmd_clear && !busy) crc_q <= '0;
        else if (lane_fire)          crc_q <= crc_next;
    end

    assign result = crc_q;
endmodule

// File: rtl/crc_scan_chk.sv
// Protocol and timing checks for flash_crc_scan, attached with bind.
module crc_scan_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_clear,
    input logic        cmd_start,
    input logic        busy,
    input logic        done,
    input logic [31:0] result,
    input logic        mem_req,
    input logic [8:0]  mem_len,
    input logic        mem_rready
);
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cmd_clear && !cmd_start) |=> $stable(result));
    assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_clear && !busy) |=> (result == 32'h0));
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_start && !busy) |=> busy);
    assert_req_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && mem_len != 9'd0 && mem_len <= 9'd256));
    assert_rready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rready |-> (busy && !mem_req));
endmodule

bind flash_crc_scan crc_scan_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_clear  (cmd_clear),
    .cmd_start  (cmd_start),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .mem_req    (mem_req),
    .mem_len    (mem_len),
    .mem_rready (mem_rready)
);

// File: tb/test_flash_crc_scan.sv
`timescale 1ns/1ps
module test_flash_crc_scan;
    localparam int ADDR_W    = 13;
    localparam int SECT_LOG2 = 8;
    localparam int SECT_W    = ADDR_W - SECT_LOG2;
    localparam int WA_W      = ADDR_W - 5;
    localparam int NLANE     = 1 << (ADDR_W - 2);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0, cmd_clear = 1'b0, cmd_start = 1'b0, cfg_sector_mode = 1'b0;
    logic burst_wr = 1'b0;
    logic [1:0] burst_code = 2'd0;
    logic [ADDR_W-1:0] cfg_start_addr = '0, cfg_end_addr = '0;
    logic [SECT_W-1:0] cfg_sector = '0;
    logic [SECT_W:0]   cfg_sector_num = '0;
    logic busy, done, mem_req, mem_rvalid, mem_rready;
    logic [31:0] result;
    logic [WA_W-1:0] mem_addr;
    logic [8:0] mem_len;
    logic [255:0] mem_rdata;

    flash_crc_scan #(.ADDR_W(ADDR_W), .SECT_LOG2(SECT_LOG2)) i_flash_crc_scan (.*);

    // Memory model: 32-bit lane values, byte at lowest address in bits 7:0.
    logic [31:0] mem32 [NLANE];
    logic [WA_W-1:0] pend_addr;
    logic [8:0] pend_left;
    logic log_clr = 1'b0;
    int req_cnt, first_len, first_addr, cyc, n_chk, n_fail;

    assign mem_rvalid = (pend_left != 9'd0);
    always_comb begin
        for (int k = 0; k < 8; k++) mem_rdata[32*k +: 32] = mem32[{pend_addr, 3'(k)}];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            pend_left <= '0; pend_addr <= '0;
        end else if (mem_req) begin
            pend_addr <= mem_addr; pend_left <= mem_len;
        end else if (mem_rvalid && mem_rready) begin
            pend_addr <= pend_addr + 1'b1; pend_left <= pend_left - 9'd1;
        end
        if (log_clr) begin
            req_cnt <= 0; first_len <= 0; first_addr <= 0;
        end else if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (req_cnt == 0) begin first_len <= int'(mem_len); first_addr <= int'(mem_addr); end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] crc_ref(input logic [31:0] init, input int lo, input int hi);
        logic [31:0] s = init;
        for (int l = lo; l <= hi; l++) begin
            s ^= mem32[l];
            for (int b = 0; b < 32; b++) s = s[31] ? ((s << 1) ^ 32'h04C11DB7) : (s << 1);
            s ^= 32'h55555555;
        end
        return s;
    endfunction

    task automatic set_byte(input int a, input logic [7:0] v);
        mem32[a >> 2][8*(a % 4) +: 8] = v;
    endtask

    task automatic do_clear();
        @(negedge clk); cmd_clear = 1'b1;
        @(negedge clk); cmd_clear = 1'b0;
    endtask

    task automatic set_burst(input logic [1:0] c);
        @(negedge clk); burst_wr = 1'b1; burst_code = c;
        @(negedge clk); burst_wr = 1'b0;
    endtask

    task automatic launch(input bit sec, input int a, input int b);
        @(negedge clk);
        cfg_sector_mode = sec;
        if (sec) begin cfg_sector = SECT_W'(a); cfg_sector_num = (SECT_W+1)'(b); end
        else begin cfg_start_addr = ADDR_W'(a); cfg_end_addr = ADDR_W'(b); end
        log_clr = 1'b1; cmd_start = 1'b1;
        @(negedge clk); log_clr = 1'b0; cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        if (!done) chk("R8 done never seen", 32'd0, 32'd1);
    endtask

    task automatic run(input bit sec, input int a, input int b);
        launch(sec, a, b); wait_done();
    endtask

    initial begin : watchdog
        wait (cyc >= 150000);
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] r1, c;
        for (int i = 0; i < NLANE; i++) mem32[i] = (32'(i) * 32'h9E3779B1) ^ 32'(i << 19);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 reset result", result, 32'h0);
        chk("R2 reset busy/done", {30'd0, busy, done}, 32'h0);

        // R5 default burst code selects 16 words; R7 sector window.
        do_clear(); run(1'b1, 0, 2);
        chk("R5 default burst len", first_len, 16);
        chk("R4 request count", req_cnt, 1);
        chk("R7 sectors 0..1 crc", result, crc_ref(0, 0, 127));

        // R5 every code, written in an order where OR-ing would fail.
        foreach (r1[i]) if (i < 4) begin
            automatic logic [1:0] code = (i == 0) ? 2'd3 : (i == 1) ? 2'd2 : (i == 2) ? 2'd0 : 2'd1;
            automatic int bl = 4 << (2 * code);
            set_burst(code); do_clear(); run(1'b1, 0, 32);
            chk("R5 burst len", first_len, bl);
            chk("R4 burst count", req_cnt, 256 / bl);
            chk("R4 first address", first_addr, 0);
            chk("R3 full memory crc", result, crc_ref(0, 0, NLANE - 1));
        end

        // R6 exhaustive lane windows inside memory word 3, low bits varied.
        for (int sl = 0; sl < 8; sl++) begin
            for (int el = sl; el < 8; el++) begin
                do_clear(); run(1'b0, 96 + 4*sl + (sl % 4), 96 + 4*el + (el % 4));
                chk("R6 lane window crc", result, crc_ref(0, 24 + sl, 24 + el));
            end
        end

        // R6 end address bits 1:0 have no effect over a multi-word span.
        for (int b = 0; b < 4; b++) begin
            do_clear(); run(1'b0, 36 + b, 600 + b);
            chk("R6 end low bits ignored", result, crc_ref(0, 9, 150));
        end
        do_clear(); run(1'b0, 28, 1023);
        chk("R6 partial first word", result, crc_ref(0, 7, 255));

        // R7 sector sweep.
        for (int f = 0; f < 4; f++) begin
            for (int n = 1; n < 4; n++) begin
                do_clear(); run(1'b1, f, n);
                chk("R7 sector crc", result, crc_ref(0, f*64, f*64 + n*64 - 1));
                chk("R7 sector first word", first_addr, f * 8);
            end
        end

        // R8 single-cycle done and result hold.
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, done}, 32'h0);
        r1 = result;
        repeat (10) @(negedge clk);
        chk("R8 result held", result, r1);

        // R10 second start without clear continues.
        do_clear(); run(1'b0, 0, 127); r1 = result;
        run(1'b0, 200, 399);
        chk("R10 continue from result", result, crc_ref(r1, 50, 99));

        // R9 start while busy is ignored.
        set_burst(2'd1); do_clear(); launch(1'b0, 0, 1023);
        repeat (20) @(negedge clk);
        chk("R9 busy before restart", {31'd0, busy}, 32'h1);
        cfg_start_addr = ADDR_W'(4000); cfg_end_addr = ADDR_W'(4031);
        cmd_start = 1'b1; @(negedge clk); cmd_start = 1'b0;
        wait_done();
        chk("R9 crc unaffected", result, crc_ref(0, 0, 255));
        chk("R9 request count", req_cnt, 2);

        // R2 clear while busy is ignored; clear while idle zeroes.
        do_clear(); launch(1'b0, 0, 511);
        repeat (30) @(negedge clk);
        cmd_clear = 1'b1; @(negedge clk); cmd_clear = 1'b0;
        wait_done();
        chk("R2 busy clear ignored", result, crc_ref(0, 0, 127));
        do_clear();
        chk("R2 idle clear", result, 32'h0);

        // R1 / R3 known answers: zero lane, and a single 1 in the lowest byte.
        for (int a = 6000; a < 6008; a++) set_byte(a, 8'h00);
        set_byte(6000, 8'h01);
        do_clear(); run(1'b0, 6000, 6003);
        chk("R3 low byte known answer", result, 32'h519448E2);
        do_clear(); run(1'b0, 6004, 6007);
        chk("R1 zero lane", result, 32'h55555555);

        // R11 image that ends with its own CRC.
        c = crc_ref(0, 1024, 1099);
        mem32[1100] = c;
        do_clear(); run(1'b0, 4096, 4403);
        chk("R11 self-check residue", result, 32'h55555555);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule